// File: doc/BRIEF.md
# Vector condition-field to integer packer

This block turns a stream of 4-bit condition fields into packed integer words. A start pulse captures a job: the element count, a 4-bit mask, a 4-bit mode pattern, a source packing code and a destination width code. The block then takes one condition field per accepted handshake, in ascending element order. For each field it forms a 4-bit predicate: a bit is set only where the mask bit is set and the field bit matches the mode bit.

Successive predicates are placed side by side into a destination word. The source packing code says how many predicates should share one word. The destination width code caps that count at the number of 4-bit slots the destination width has. Each finished word leaves on a valid/ready output stream, tagged with its destination index. Bits outside the occupied slots are zero. A word that is only partly filled when the last element arrives is sent with its empty slots at zero. A one-cycle done pulse closes the job.

Top module: `cond_pack_top`

## Requirements
- R1: For condition field c, predicate bit k (k = 0..3) is mask[k] AND (mode[k] == c[k]). The 4-bit result is {n0,n1,n2,n3}, so n0 sits in result bit 3 and n3 in result bit 0.
- R2: Destination width code 2'b00 selects 64 bits, 2'b01 selects 8 bits, 2'b10 selects 16 bits and 2'b11 selects 32 bits.
- R3: Source packing code 2'b01 asks for 4 predicates per word and 2'b10 asks for 8. Codes 2'b00 and 2'b11 ask for 1. The count used is the smaller of the request and width/4.
- R4: Within a word, the j-th predicate (j from 0) occupies bits [4j+3:4j].
- R5: Every bit of out_data outside the occupied slots is 0. This includes every bit at or above the selected width.
- R6: After the last element, a partly filled word is emitted with its unfilled slots at zero.
- R7: Elements are consumed in order 0..VL-1. out_idx counts the words of a job from 0 upward in steps of 1.
- R8: A start with VL = 0 emits no word. The block stays idle, and done pulses in the cycle after the start.
- R9: While out_valid is high and out_ready is low, out_valid, out_data and out_idx hold their values.
- R10: done pulses for one cycle, in the cycle after the final word's handshake.
- R11: cf_ready is low after reset, while idle, and whenever a word is waiting on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a job when idle |
| vl | input | VL_W | Number of condition fields in the job |
| mask | input | 4 | Predicate mask |
| mode | input | 4 | Pattern compared with each field |
| src_pack | input | 2 | Requested predicates per word |
| dst_width | input | 2 | Destination width code |
| cf_valid | input | 1 | Condition field valid |
| cf_data | input | 4 | Condition field |
| cf_ready | output | 1 | Condition field accepted this cycle if valid |
| out_valid | output | 1 | Packed word valid |
| out_ready | input | 1 | Consumer accepts packed word |
| out_data | output | DATA_W | Packed word, zero-filled |
| out_idx | output | VL_W | Destination index of the word |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
The hardest situation to reach is the output stalling while a partial final word is pending. In that state the last element has already been taken, the done pulse must wait for the stalled handshake, and no further field may be accepted. The stimulus table mixes element counts that are not multiples of the slot count with an output-ready pattern that drops every third cycle, so the final word often lands on a stall. Rows whose requested count exceeds what the width allows, such as 4 requested into 8 bits or 8 into 16, exercise the cap.

// File: rtl/cond_pack_pkg.sv
package cond_pack_pkg;

   localparam int SLOT_W = 4;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2
   } pk_state_e;

   // bit width selected by a destination width code
   function automatic int width_bits(input logic [1:0] code);
      case (code)
         2'b01:   return 8;
         2'b10:   return 16;
         2'b11:   return 32;
         default: return 64;
      endcase
   endfunction

   // predicates per destination word after the width cap
   function automatic int slot_count(input logic [1:0] src, input logic [1:0] dst);
      int req;
      int cap;
      case (src)
         2'b01:   req = 4;
         2'b10:   req = 8;
         default: req = 1;
      endcase
      cap = width_bits(dst) / SLOT_W;
      return (req < cap) ? req : cap;
   endfunction

endpackage

// File: rtl/cond_pack_pred.sv
module cond_pack_pred
   import cond_pack_pkg::*;
(
   input  logic [SLOT_W-1:0] cond,
   input  logic [SLOT_W-1:0] mask,
   input  logic [SLOT_W-1:0] mode,
   output logic [SLOT_W-1:0] res
);

   // bit k of the field lands in result bit SLOT_W-1-k (first bit is MSB)
   for (genvar k = 0; k < SLOT_W; k++) begin : g_bit
      assign res[SLOT_W-1-k] = mask[k] & ~(mode[k] ^ cond[k]);
   end

endmodule

// File: rtl/cond_pack_insert.sv
module cond_pack_insert
   import cond_pack_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0]                    acc,
   input  logic [$clog2(DATA_W/SLOT_W)-1:0]     slot,
   input  logic [SLOT_W-1:0]                    res,
   output logic [DATA_W-1:0]                    acc_nxt
);

   localparam int NSLOT = DATA_W / SLOT_W;
   localparam int SI_W  = $clog2(NSLOT);

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign acc_nxt[s*SLOT_W +: SLOT_W] =
         (slot == SI_W'(s)) ? res : acc[s*SLOT_W +: SLOT_W];
   end

endmodule

// File: rtl/cond_pack_obuf.sv
module cond_pack_obuf #(
   parameter int DATA_W = 64,
   parameter int IDX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] ld_data,
   input  logic [IDX_W-1:0]  ld_idx,
   input  logic              ready,
   output logic              valid,
   output logic [DATA_W-1:0] data,
   output logic [IDX_W-1:0]  idx
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         data  <= '0;
         idx   <= '0;
      end else if (load) begin
         valid <= 1'b1;
         data  <= ld_data;
         idx   <= ld_idx;
      end else if (valid && ready) begin
         valid <= 1'b0;
      end
   end

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !ready |=> valid && $stable(data) && $stable(idx));

endmodule

// File: rtl/cond_pack_top.sv
module cond_pack_top
   import cond_pack_pkg::*;
#(
   parameter int VL_W   = 8,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [VL_W-1:0]   vl,
   input  logic [3:0]        mask,
   input  logic [3:0]        mode,
   input  logic [1:0]        src_pack,
   input  logic [1:0]        dst_width,
   input  logic              cf_valid,
   input  logic [3:0]        cf_data,
   output logic              cf_ready,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic [VL_W-1:0]   out_idx,
   output logic              busy,
   output logic              done
);

   localparam int NSLOT = DATA_W / SLOT_W;
   localparam int SI_W  = $clog2(NSLOT);
   localparam int CNT_W = SI_W + 1;

   if (DATA_W != 64) begin : g_bad_width
      $error("cond_pack_top: DATA_W must be 64 to cover every width code");
   end
   if (VL_W < 1) begin : g_bad_vl
      $error("cond_pack_top: VL_W must be at least 1");
   end

   pk_state_e         st_q;
   logic [VL_W-1:0]   vl_q, in_cnt_q, didx_q;
   logic [3:0]        mask_q, mode_q;
   logic [1:0]        dst_q;
   logic [CNT_W-1:0]  per_q;
   logic [SI_W-1:0]   slot_q;
   logic [DATA_W-1:0] acc_q, acc_nxt, wmask;
   logic [3:0]        res;
   logic              done_q, take, last_in, close_word;

   cond_pack_pred u_pred (
      .cond (cf_data),
      .mask (mask_q),
      .mode (mode_q),
      .res  (res)
   );

   cond_pack_insert #(.DATA_W(DATA_W)) u_ins (
      .acc     (acc_q),
      .slot    (slot_q),
      .res     (res),
      .acc_nxt (acc_nxt)
   );

   assign cf_ready   = (st_q == ST_RUN) && !out_valid;
   assign take       = cf_valid && cf_ready;
   assign last_in    = (in_cnt_q == vl_q - 1'b1);
   assign close_word = ({1'b0, slot_q} == per_q - 1'b1) || last_in;
   assign busy       = (st_q != ST_IDLE);
   assign done       = done_q;

   cond_pack_obuf #(.DATA_W(DATA_W), .IDX_W(VL_W)) u_obuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (take && close_word),
      .ld_data (acc_nxt),
      .ld_idx  (didx_q),
      .ready   (out_ready),
      .valid   (out_valid),
      .data    (out_data),
      .idx     (out_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         vl_q     <= '0;
         in_cnt_q <= '0;
         didx_q   <= '0;
         mask_q   <= '0;
         mode_q   <= '0;
         dst_q    <= '0;
         per_q    <= '0;
         slot_q   <= '0;
         acc_q    <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: if (start) begin
               if (vl == '0) begin
                  done_q <= 1'b1;
               end else begin
                  st_q     <= ST_RUN;
                  vl_q     <= vl;
                  mask_q   <= mask;
                  mode_q   <= mode;
                  dst_q    <= dst_width;
                  per_q    <= CNT_W'(slot_count(src_pack, dst_width));
                  in_cnt_q <= '0;
                  didx_q   <= '0;
                  slot_q   <= '0;
                  acc_q    <= '0;
               end
            end
            ST_RUN: if (take) begin
               in_cnt_q <= in_cnt_q + 1'b1;
               if (close_word) begin
                  acc_q  <= '0;
                  slot_q <= '0;
                  didx_q <= didx_q + 1'b1;
               end else begin
                  acc_q  <= acc_nxt;
                  slot_q <= slot_q + 1'b1;
               end
               if (last_in) st_q <= ST_DRAIN;
            end
            ST_DRAIN: if (out_valid && out_ready) begin
               st_q   <= ST_IDLE;
               done_q <= 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // slots that fit inside the selected destination width
   for (genvar s = 0; s < NSLOT; s++) begin : g_wmask
      assign wmask[s*SLOT_W +: SLOT_W] = {SLOT_W{(s * SLOT_W) < width_bits(dst_q)}};
   end

   // R5
   zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data & ~wmask) == '0);

   // R8
   empty_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && vl == '0 |=> done && !busy && !out_valid);

   // R10
   done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(out_valid && out_ready) || $past(start && vl == '0));

   // R11
   no_accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !cf_ready);

endmodule

// File: tb/tb_cond_pack_top.sv
`timescale 1ns/1ps
module tb_cond_pack_top;

   localparam int VL_W   = 8;
   localparam int DATA_W = 64;

   typedef struct packed {
      logic [7:0] vl;
      logic [3:0] mask;
      logic [3:0] mode;
      logic [1:0] src;
      logic [1:0] dst;
      logic [3:0] seed;
      logic       stall;
   } vec_t;

   localparam int NVEC = 10;
   localparam vec_t VECS [NVEC] = '{
      '{8'd8,  4'hF, 4'hA, 2'd1, 2'd2, 4'd1, 1'b1},
      '{8'd5,  4'hF, 4'h3, 2'd2, 2'd3, 4'd2, 1'b0},
      '{8'd3,  4'h9, 4'h0, 2'd0, 2'd0, 4'd3, 1'b1},
      '{8'd7,  4'hF, 4'hF, 2'd1, 2'd1, 4'd4, 1'b1},
      '{8'd20, 4'h6, 4'h5, 2'd2, 2'd0, 4'd5, 1'b0},
      '{8'd9,  4'hF, 4'h0, 2'd3, 2'd2, 4'd6, 1'b1},
      '{8'd17, 4'hF, 4'hC, 2'd2, 2'd1, 4'd7, 1'b1},
      '{8'd1,  4'hF, 4'h7, 2'd1, 2'd3, 4'd8, 1'b1},
      '{8'd12, 4'h0, 4'h5, 2'd2, 2'd2, 4'd9, 1'b0},
      '{8'd16, 4'hE, 4'hB, 2'd1, 2'd0, 4'd10, 1'b1}
   };

   logic              clk = 1'b0;
   logic              rst_n;
   logic              start;
   logic [VL_W-1:0]   vl;
   logic [3:0]        mask, mode;
   logic [1:0]        src_pack, dst_width;
   logic              cf_valid;
   logic [3:0]        cf_data;
   logic              cf_ready;
   logic              out_valid;
   logic              out_ready;
   logic [DATA_W-1:0] out_data;
   logic [VL_W-1:0]   out_idx;
   logic              busy, done;

   int checks   = 0;
   int failures = 0;

   always #10 clk = ~clk;

   cond_pack_top #(.VL_W(VL_W), .DATA_W(DATA_W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .mask(mask), .mode(mode),
      .src_pack(src_pack), .dst_width(dst_width), .cf_valid(cf_valid),
      .cf_data(cf_data), .cf_ready(cf_ready), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .out_idx(out_idx),
      .busy(busy), .done(done)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] cond_of(input int seed, input int i);
      return 4'((seed * 5 + i * 7 + (i >> 2)) & 15);
   endfunction

   function automatic logic [3:0] pred_of(input logic [3:0] c, input logic [3:0] m,
                                          input logic [3:0] p);
      logic [3:0] r;
      for (int k = 0; k < 4; k++) r[3-k] = m[k] & (p[k] == c[k]);
      return r;
   endfunction

   function automatic int per_word(input logic [1:0] src, input logic [1:0] dst);
      int w, req;
      w   = (dst == 2'd0) ? 64 : (dst == 2'd1) ? 8 : (dst == 2'd2) ? 16 : 32;
      req = (src == 2'd1) ? 4 : (src == 2'd2) ? 8 : 1;
      return (req < w / 4) ? req : w / 4;
   endfunction

   function automatic logic [63:0] exp_word(input vec_t v, input int d);
      logic [63:0] acc = '0;
      int per = per_word(v.src, v.dst);
      for (int j = 0; j < per; j++) begin
         if (d * per + j < int'(v.vl))
            acc[4*j +: 4] = pred_of(cond_of(int'(v.seed), d * per + j), v.mask, v.mode);
      end
      return acc;
   endfunction

   task automatic run_job(input vec_t v);
      int per    = per_word(v.src, v.dst);
      int nbeats = (int'(v.vl) + per - 1) / per;
      int beat   = 0;
      int in_i   = 0;
      int cyc    = 0;
      bit seen   = 0;
      bit held   = 0;
      bit got_done = 0;
      logic [63:0] held_d = '0;
      logic [VL_W-1:0] held_i = '0;
      @(negedge clk);
      vl = v.vl; mask = v.mask; mode = v.mode; src_pack = v.src; dst_width = v.dst;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (cyc < 2000) begin
         if (done) begin
            got_done = 1;
            break;
         end
         out_ready = v.stall ? (cyc % 3 != 1) : 1'b1;
         if (out_valid) begin
            // R11: no field accepted while a word waits
            check(!cf_ready, "R11", 64'(cf_ready), 64'd0);
            if (held) begin
               // R9
               check(out_data == held_d && out_idx == held_i, "R9", out_data, held_d);
            end
            if (!seen) begin
               // R1 R2 R3 R4 R5 R6
               check(out_data == exp_word(v, beat), "R1 R3 R4 R5 R6",
                     out_data, exp_word(v, beat));
               // R7
               check(int'(out_idx) == beat, "R7", 64'(out_idx), 64'(beat));
               seen = 1;
            end
            if (out_ready) begin
               beat++;
               seen = 0;
               held = 0;
            end else begin
               held   = 1;
               held_d = out_data;
               held_i = out_idx;
            end
         end
         if (in_i < int'(v.vl)) begin
            cf_valid = 1'b1;
            cf_data  = cond_of(int'(v.seed), in_i);
            if (cf_ready) in_i++;
         end else begin
            cf_valid = 1'b0;
         end
         @(negedge clk);
         cyc++;
      end
      cf_valid = 1'b0;
      // R10
      check(got_done && beat == nbeats, "R10", 64'(beat), 64'(nbeats));
      // R7
      check(in_i == int'(v.vl), "R7", 64'(in_i), 64'(v.vl));
      @(negedge clk);
      // R10: single-cycle pulse
      check(!done && !busy, "R10", 64'(done), 64'd0);
   endtask

   initial begin
      #(20 * 150000);
      failures++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; vl = '0; mask = '0; mode = '0;
      src_pack = '0; dst_width = '0; cf_valid = 1'b0; cf_data = '0; out_ready = 1'b1;
      repeat (3) @(negedge clk);
      // R11: reset state
      check(!cf_ready && !out_valid && !done && !busy, "R11",
            {60'd0, cf_ready, out_valid, done, busy}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!cf_ready, "R11", 64'(cf_ready), 64'd0);

      for (int n = 0; n < NVEC; n++) run_job(VECS[n]);

      // R8: empty job
      @(negedge clk);
      vl = '0; start = 1'b1; cf_valid = 1'b1; cf_data = 4'h5;
      @(negedge clk);
      start = 1'b0;
      check(done && !busy && !out_valid && !cf_ready, "R8",
            {60'd0, done, busy, out_valid, cf_ready}, 64'h8);
      @(negedge clk);
      check(!done && !out_valid, "R8", {62'd0, done, out_valid}, 64'd0);
      cf_valid = 1'b0;

      // R2 R3: 8 requested into 32 bits gives 8 per word, full single word
      run_job('{8'd8, 4'hF, 4'h6, 2'd2, 2'd3, 4'd11, 1'b1});

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule